// File: doc/BRIEF.md
# I2C Bus Timing Generator

This block produces the SCL and SDA waveforms of an I2C controller one symbol at a time: a START (first or repeated), a STOP, a transmitted bit or a received bit. A byte engine above it issues one request, waits for the `done` pulse, then issues the next one. Four run-time counts, all in system clock cycles, set the timing: the full SCL period, the SCL low time, the setup/hold time around START and STOP, and the SDA-to-SCL-rise data setup time. Usual settings are: period = clock rate / bus rate (bus rate up to 400 kHz, 100 kHz typical), low time and start/stop setup = period/2, and data setup = period/16. Both bus lines are open drain. The block only pulls a line low (`scl_pull`, `sda_pull`) and reads the real levels back on `scl_in` and `sda_in`. A slave may therefore stretch the clock.

The controller is built around one state machine. ST_IDLE waits for a request. ST_LOW holds SCL low and changes SDA late in the phase. ST_WAIT_HI has released SCL and waits for the line to read high. ST_HIGH counts the high phase, or the START/STOP setup time. ST_HOLD keeps SDA low after a START edge until SCL is pulled low. The transitions are as follows:
- Accept: ST_IDLE goes to ST_LOW when the block already owns the bus, or to ST_WAIT_HI when it does not.
- Low end: ST_LOW goes to ST_WAIT_HI.
- Sensed high: ST_WAIT_HI goes to ST_HIGH.
- High end: ST_HIGH goes to ST_HOLD for a START, or to ST_IDLE for anything else.
- Hold end: ST_HOLD goes to ST_IDLE.
- Override: any state goes to ST_IDLE.

For bus recovery, `ovr_en` hands SCL to software. While it is set, `ovr_scl` drives the line directly and the state machine stays idle.

Top module: `i2c_bus_timer`

## Requirements
- R1: After reset, `scl_pull`, `sda_pull`, `busy` and `done` are all 0.
- R2: While `cfg_period` is 0, a request is not accepted. `busy` and `done` stay 0 and neither line is pulled.
- R3: A request is accepted when `req_valid` is 1 in ST_IDLE. If the bus is owned, meaning SCL is held low after an earlier START or bit, `scl_pull` falls exactly `cfg_low` cycles after the accepting edge.
- R4: During the low phase, SDA takes its new value `cfg_dsu` cycles before SCL is released. The new value is: WRITE with bit 0 pulls SDA; WRITE with bit 1, READ and START release it; STOP pulls it.
- R5: For a WRITE or READ, SCL reads high for `cfg_period - cfg_low` cycles. Then `scl_pull` rises and `done` pulses in that same cycle.
- R6: Timing of the high phase begins only once `scl_in` reads high. A slave that holds SCL low delays the phase without shortening it.
- R7: For a READ, `rx_bit` takes the `sda_in` level of cycle number (`cfg_period - cfg_low`)/2 of the high phase, counting from 1.
- R8: A START from an idle bus pulls SDA `cfg_sus` cycles after acceptance. It then pulls SCL and pulses `done` a further `cfg_sus` cycles later.
- R9: A repeated START (bus owned) releases SDA and SCL as in R3/R4. After SCL reads high it pulls SDA after `cfg_sus` cycles, then pulls SCL and pulses `done` `cfg_sus` cycles later.
- R10: A STOP pulls SDA in the low phase and releases SCL. After `cfg_sus` high cycles it releases SDA and pulses `done`, and the bus is left released.
- R11: While `ovr_en` is 1, `scl_pull` equals the inverse of `ovr_scl`, SDA is released, any operation in progress is abandoned, and requests are ignored.
- R12: `done` is a single-cycle pulse. `busy` is 1 from acceptance until `done`. Requests made while busy are ignored.
- Encoding: `req_op` is 00 START, 01 STOP, 10 WRITE, 11 READ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_period | input | CW | Full SCL period in cycles; 0 disables |
| cfg_low | input | CW | SCL low time in cycles |
| cfg_sus | input | CW | START/STOP setup and hold time |
| cfg_dsu | input | CW | SDA change to SCL rise setup time |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | Operation code (see encoding) |
| req_bit | input | 1 | Bit to send for WRITE |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| ovr_en | input | 1 | Recovery override enable |
| ovr_scl | input | 1 | SCL level under override (1 releases) |
| scl_pull | output | 1 | Pull SCL low |
| sda_pull | output | 1 | Pull SDA low |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation complete pulse |
| rx_bit | output | 1 | Last received bit |

## Verification
The assertions assume that the configuration is held steady while an operation runs, with `cfg_dsu` ≥ 1 and below `cfg_low`, `cfg_sus` ≥ 2, and a high phase of at least 4 cycles. They also assume that `scl_in` and `sda_in` are the wired-AND of this block's pulls and the other devices on the bus. The bench builds both lines exactly that way from `scl_pull`/`sda_pull` plus a modelled slave that stretches SCL and drives read data. It changes the configuration only between operations, and it sweeps low times, high times, data setups and setup times only inside those bounds.

// File: rtl/i2c_tg_pkg.sv
package i2c_tg_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'b00,
        OP_STOP  = 2'b01,
        OP_WRITE = 2'b10,
        OP_READ  = 2'b11
    } tg_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_WAIT_HI,
        ST_HIGH,
        ST_HOLD
    } tg_state_e;

endpackage

// File: rtl/i2c_tg_lengths.sv
// Derives the phase lengths and event points from the programmed counts.
module i2c_tg_lengths #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] cfg_period,
    input  logic [CW-1:0] cfg_low,
    input  logic [CW-1:0] cfg_dsu,
    output logic [CW-1:0] hi_len,
    output logic [CW-1:0] sda_pt,
    output logic [CW-1:0] mid_pt
);
    localparam logic [CW-1:0] ONE = CW'(1);
    localparam logic [CW-1:0] TWO = CW'(2);

    logic [CW-1:0] half_hi;

    always_comb begin
        hi_len  = (cfg_period > cfg_low) ? cfg_period - cfg_low : ONE;
        sda_pt  = (cfg_low > cfg_dsu) ? cfg_low - cfg_dsu : ONE;
        half_hi = {1'b0, hi_len[CW-1:1]};
        mid_pt  = (half_hi >= TWO) ? half_hi : TWO;
    end
endmodule

// File: rtl/i2c_tg_counter.sv
// Phase counter: loads a start value, otherwise counts up and saturates.
module i2c_tg_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_bus_timer.sv
module i2c_bus_timer
    import i2c_tg_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cfg_period,
    input  logic [CW-1:0] cfg_low,
    input  logic [CW-1:0] cfg_sus,
    input  logic [CW-1:0] cfg_dsu,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic          req_bit,
    input  logic          scl_in,
    input  logic          sda_in,
    input  logic          ovr_en,
    input  logic          ovr_scl,
    output logic          scl_pull,
    output logic          sda_pull,
    output logic          busy,
    output logic          done,
    output logic          rx_bit
);
    localparam logic [CW-1:0] LOAD_LOW  = CW'(1);
    localparam logic [CW-1:0] LOAD_HIGH = CW'(2);

    tg_state_e     state, state_nx;
    tg_op_e        cur_op;
    logic          cur_bit;
    logic          owned;
    logic          scl_lo;
    logic          sda_lo;
    logic [CW-1:0] cnt;
    logic [CW-1:0] hi_len, sda_pt, mid_pt, phase_len;
    logic          accept, low_end, hi_seen, high_end, hold_end, sda_hit;
    logic          cnt_load;
    logic [CW-1:0] cnt_load_val;
    logic          is_edge_op;
    logic          sda_target;

    i2c_tg_lengths #(.CW(CW)) u_len (
        .cfg_period (cfg_period),
        .cfg_low    (cfg_low),
        .cfg_dsu    (cfg_dsu),
        .hi_len     (hi_len),
        .sda_pt     (sda_pt),
        .mid_pt     (mid_pt)
    );

    i2c_tg_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .cnt      (cnt)
    );

    // Phase events
    always_comb begin
        is_edge_op   = (cur_op == OP_START) || (cur_op == OP_STOP);
        phase_len    = is_edge_op ? cfg_sus : hi_len;
        accept       = (state == ST_IDLE) && req_valid && !ovr_en && (cfg_period != '0);
        low_end      = (state == ST_LOW) && (cnt >= cfg_low);
        hi_seen      = (state == ST_WAIT_HI) && scl_in;
        high_end     = (state == ST_HIGH) && (cnt >= phase_len);
        hold_end     = (state == ST_HOLD) && (cnt >= cfg_sus);
        sda_hit      = (state == ST_LOW) && (cnt == sda_pt);
        cnt_load     = accept || hi_seen || (high_end && (cur_op == OP_START));
        cnt_load_val = hi_seen ? LOAD_HIGH : LOAD_LOW;
        unique case (cur_op)
            OP_WRITE: sda_target = !cur_bit;
            OP_STOP:  sda_target = 1'b1;
            default:  sda_target = 1'b0;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (ovr_en) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    if (accept)   state_nx = owned ? ST_LOW : ST_WAIT_HI;
                ST_LOW:     if (low_end)  state_nx = ST_WAIT_HI;
                ST_WAIT_HI: if (scl_in)   state_nx = ST_HIGH;
                ST_HIGH:    if (high_end) state_nx = (cur_op == OP_START) ? ST_HOLD : ST_IDLE;
                ST_HOLD:    if (hold_end) state_nx = ST_IDLE;
                default:                  state_nx = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Line drive, completion and capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_op  <= OP_START;
            cur_bit <= 1'b0;
            owned   <= 1'b0;
            scl_lo  <= 1'b0;
            sda_lo  <= 1'b0;
            done    <= 1'b0;
            rx_bit  <= 1'b0;
        end else if (ovr_en) begin
            owned  <= 1'b0;
            scl_lo <= 1'b0;
            sda_lo <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                cur_op  <= tg_op_e'(req_op);
                cur_bit <= req_bit;
            end
            if (sda_hit) begin
                sda_lo <= sda_target;
            end
            if (low_end) begin
                scl_lo <= 1'b0;
            end
            if ((state == ST_HIGH) && (cnt == mid_pt) && (cur_op == OP_READ)) begin
                rx_bit <= sda_in;
            end
            if (high_end) begin
                unique case (cur_op)
                    OP_START: sda_lo <= 1'b1;
                    OP_STOP: begin
                        sda_lo <= 1'b0;
                        owned  <= 1'b0;
                        done   <= 1'b1;
                    end
                    default: begin
                        scl_lo <= 1'b1;
                        owned  <= 1'b1;
                        done   <= 1'b1;
                    end
                endcase
            end
            if (hold_end) begin
                scl_lo <= 1'b1;
                owned  <= 1'b1;
                done   <= 1'b1;
            end
        end
    end

    assign scl_pull = ovr_en ? !ovr_scl : scl_lo;
    assign sda_pull = sda_lo;
    assign busy     = (state != ST_IDLE);

    // Assertions
    a_r2_zero_period_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cfg_period == '0) |=> (state == ST_IDLE));
    a_r3_low_phase_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOW) |-> scl_lo);
    a_r5_high_phase_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH) |-> !scl_lo);
    a_r6_wait_for_line: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_HI && !scl_in && !ovr_en) |=> (state == ST_WAIT_HI));
    a_r8_start_edge_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_lo) && !scl_lo) |-> (state == ST_HOLD));
    a_r10_stop_edge_completes: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_lo) && !scl_lo && !$past(ovr_en)) |-> done);
    a_r11_override_idles: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_en |=> !busy);
    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/sim_i2c_bus_timer.sv
module sim_i2c_bus_timer;
    localparam int CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [CW-1:0] cfg_period = '0, cfg_low = '0, cfg_sus = '0, cfg_dsu = '0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic req_bit = 1'b0;
    logic stretch = 1'b0, slave_low = 1'b0, ovr_en = 1'b0, ovr_scl = 1'b1;
    logic scl_pull, sda_pull, busy, done, rx_bit, scl_in, sda_in;

    assign scl_in = !(scl_pull || stretch);
    assign sda_in = !(sda_pull || slave_low);

    int n_chk = 0, n_fail = 0;
    int lo, hi, su, ds;
    bit b_owned = 1'b0, hold_req = 1'b0, finished = 1'b0;

    i2c_bus_timer #(.CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_low(cfg_low),
        .cfg_sus(cfg_sus), .cfg_dsu(cfg_dsu), .req_valid(req_valid), .req_op(req_op),
        .req_bit(req_bit), .scl_in(scl_in), .sda_in(sda_in), .ovr_en(ovr_en),
        .ovr_scl(ovr_scl), .scl_pull(scl_pull), .sda_pull(sda_pull), .busy(busy),
        .done(done), .rx_bit(rx_bit)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input int l, input int h, input int s, input int d);
        lo = l; hi = h; su = s; ds = d;
        cfg_period = CW'(l + h);
        cfg_low    = CW'(l);
        cfg_sus    = CW'(s);
        cfg_dsu    = CW'(d);
    endtask

    // op: 0 START, 1 STOP, 2 WRITE, 3 READ
    task automatic run_op(input logic [1:0] op, input logic b, input int s);
        int rel_i = -1, hs = -1, dn = -1, chg = -1, fall = -1;
        int mid, scl_d = 0, sda_d = 0, sda_rel = 0;
        bit was_owned, line_hi;
        logic old, tgt;
        was_owned = b_owned;
        old = sda_pull;
        mid = hi / 2;
        tgt = (op == 2'd2) ? !b : (op == 2'd1);
        req_valid = 1'b1; req_op = op; req_bit = b;
        stretch = (s > 0) && was_owned;
        tick();
        for (int i = 0; i < 300; i++) begin
            if (!hold_req) req_valid = 1'b0;
            if (was_owned && rel_i < 0 && chg < 0 && sda_pull != old) chg = i;
            if (was_owned && rel_i < 0 && !scl_pull) begin
                rel_i = i;
                sda_rel = sda_pull;
            end
            stretch = (s > 0) && was_owned && !(rel_i >= 0 && i >= rel_i + s);
            line_hi = !scl_pull && !stretch;
            if (hs < 0 && line_hi && (!was_owned || rel_i >= 0)) hs = i;
            if (op == 2'd0 && hs >= 0 && fall < 0 && sda_pull) fall = i;
            slave_low = (op == 2'd3) && ((hs >= 0 && i - hs == mid - 1) ? !b : b);
            if (done) begin
                dn = i; scl_d = scl_pull; sda_d = sda_pull;
                req_valid = 1'b0;
                break;
            end
            tick();
        end
        req_valid = 1'b0;
        slave_low = 1'b0;
        stretch = 1'b0;
        chk(dn >= 0, "R12 done seen", dn, 0);
        if (was_owned) begin
            chk(rel_i == lo, "R3 scl low time", rel_i, lo);
            if (old != tgt) chk(chg == lo - ds, "R4 data setup", chg, lo - ds);
            chk(sda_rel == int'(tgt), "R4 sda value at release", sda_rel, int'(tgt));
            chk(hs == lo + s, "R6 stretched high start", hs, lo + s);
        end
        unique case (op)
            2'd2, 2'd3: begin
                chk(dn == hs + hi, "R5 high length", dn - hs, hi);
                chk(scl_d == 1, "R5 scl pulled at end", scl_d, 1);
                if (op == 2'd3) chk(rx_bit == b, "R7 sampled bit", int'(rx_bit), int'(b));
            end
            2'd0: begin
                if (was_owned) begin
                    chk(fall == hs + su, "R9 restart sda edge", fall, hs + su);
                    chk(dn == hs + 2 * su, "R9 restart done", dn, hs + 2 * su);
                end else begin
                    chk(fall == su, "R8 start sda edge", fall, su);
                    chk(dn == 2 * su, "R8 start done", dn, 2 * su);
                end
                chk(scl_d == 1, "R8 scl pulled after start", scl_d, 1);
            end
            default: begin
                chk(dn == hs + su, "R10 stop timing", dn - hs, su);
                chk(sda_d == 0 && scl_d == 0, "R10 bus released", sda_d + scl_d, 0);
            end
        endcase
        b_owned = (op != 2'd1);
        tick();
        chk(!done && !busy, "R12 single pulse and idle", int'(done) + int'(busy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R12 watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        set_cfg(6, 6, 3, 2);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(!scl_pull && !sda_pull && !busy && !done, "R1 reset state",
            int'(scl_pull) + int'(sda_pull) + int'(busy) + int'(done), 0);

        // R2 zero period ignores requests
        begin
            int seen = 0;
            cfg_period = '0;
            req_valid = 1'b1; req_op = 2'd0;
            for (int i = 0; i < 20; i++) begin
                tick();
                if (busy || done || scl_pull || sda_pull) seen++;
            end
            req_valid = 1'b0;
            chk(seen == 0, "R2 zero period idle", seen, 0);
        end

        // Sweep of timing configurations
        for (int l = 4; l <= 6; l++) begin
            for (int h = 4; h <= 6; h += 2) begin
                for (int d = 1; d < l; d++) begin
                    for (int s = 2; s <= 3; s++) begin
                        set_cfg(l, h, s, d);
                        run_op(2'd0, 1'b0, 0);
                        run_op(2'd2, 1'b1, 0);
                        run_op(2'd2, 1'b0, 2);
                        run_op(2'd3, 1'b1, 0);
                        run_op(2'd3, 1'b0, 3);
                        run_op(2'd2, 1'b0, 0);
                        run_op(2'd0, 1'b0, 1);
                        run_op(2'd3, 1'b1, 0);
                        run_op(2'd1, 1'b0, 0);
                    end
                end
            end
        end

        // R12 requests held while busy are ignored
        set_cfg(5, 6, 2, 2);
        run_op(2'd0, 1'b0, 0);
        hold_req = 1'b1;
        run_op(2'd2, 1'b1, 0);
        hold_req = 1'b0;
        run_op(2'd1, 1'b0, 0);

        // R11 recovery override
        ovr_en = 1'b1; ovr_scl = 1'b0;
        tick();
        chk(scl_pull == 1'b1, "R11 override pulls scl", int'(scl_pull), 1);
        ovr_scl = 1'b1;
        tick();
        chk(scl_pull == 1'b0, "R11 override releases scl", int'(scl_pull), 0);
        req_valid = 1'b1; req_op = 2'd0;
        tick(); tick();
        chk(!busy && !sda_pull, "R11 request ignored", int'(busy) + int'(sda_pull), 0);
        req_valid = 1'b0;
        ovr_en = 1'b0;
        tick();
        run_op(2'd0, 1'b0, 0);
        req_valid = 1'b1; req_op = 2'd2; req_bit = 1'b0;
        tick();
        req_valid = 1'b0;
        tick();
        chk(busy == 1'b1, "R12 busy during op", int'(busy), 1);
        ovr_en = 1'b1; ovr_scl = 1'b1;
        tick();
        chk(!busy && !sda_pull && !scl_pull, "R11 abort op",
            int'(busy) + int'(sda_pull) + int'(scl_pull), 0);
        ovr_en = 1'b0;
        tick();
        chk(!scl_pull && !busy, "R11 bus free after override", int'(scl_pull), 0);
        b_owned = 1'b0;
        run_op(2'd0, 1'b0, 0);
        run_op(2'd1, 1'b0, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule